// File: doc/BRIEF.md
# Interrupt Context Stacking Engine

This block is a small hardware sequencer that sits beside a core's integer register file, its floating-point register file, a one-word data memory port and the stack pointer. When the interrupt controller signals that a handler is being entered, the engine lowers the stack pointer by the size of a context frame and stores the sixteen caller-saved integer registers into it, one word per cycle. Handlers can then be ordinary compiled functions. When the handler returns, the engine reads the same sixteen words back into the register file and raises the stack pointer again. The core is stalled through `busy_o` while either sequence runs.

If floating point is enabled when an interrupt is taken, the frame also holds room for the twenty caller-saved floating-point registers. That room is only reserved at entry. The twenty registers are stored only when the core reports the first floating-point instruction inside the handler. On return, they are loaded back only if they were actually stored.

If another interrupt is already pending when a handler returns, the engine keeps the frame where it is and signals a direct hand-over to the next handler, with no unstacking and no restacking. Frames nest up to a parameterised depth, so higher-priority interrupts can preempt running handlers. The engine keeps the base address and the floating-point state of every open frame.

Top module: `ictx_stacker`

## Requirements
- R1: An accepted entry strobe (`entry_i` high while `busy_o` is low and fewer than NEST frames are open) writes the stack pointer in the same cycle through `sp_we_o`/`sp_wdata_o`. The new value is the old value minus 64 bytes with floating point off, or minus 144 bytes with floating point on. `busy_o` is then high for exactly 16 cycles.
- R2: Push k (k = 0..15) takes the k-th register of the list x1, x5, x6, x7, x10..x17, x28..x31. It stores that register at address old_sp − 4·(k+1) in the k-th busy cycle, so the addresses descend by 4 each cycle.
- R3: Entry never stores floating-point data: exactly 16 memory writes occur, whether or not floating point is enabled.
- R4: A `fp_use_i` strobe while the innermost frame has reserved but unfilled floating-point space stores f0..f7, f10..f17 and f28..f31, in that order. Store j goes to old_sp − 4·(17+j), one per cycle, with `busy_o` high for 20 cycles. A later `fp_use_i` strobe for the same frame causes no memory traffic.
- R5: A `fp_use_i` strobe is ignored when no frame is open, or when the innermost frame reserved no floating-point space. In that case `busy_o` stays low and no memory access occurs.
- R6: An exit strobe with `pend_i` low reloads the saved integer registers from their push addresses. If the floating-point registers were stored, it first reloads all 20 of them. `busy_o` is high for 36 or 16 cycles accordingly, and in the last cycle the stack pointer returns to its value before entry.
- R7: On exit from a frame whose floating-point space was reserved but never filled, only the 16 integer loads occur and no floating-point register is written. The stack pointer still rises by the full 144 bytes.
- R8: An exit strobe with `pend_i` high, while a frame is open, raises `tail_o` in that cycle. It causes no memory access and no stack-pointer write, `busy_o` stays low, and the frame stays open for a later exit.
- R9: An entry accepted while frames are open opens a nested frame below the current stack pointer. Exits unwind the frames in reverse order, each restoring the registers saved by its own entry.
- R10: An exit strobe with no open frame, or an entry strobe with NEST frames open, is ignored: no stack-pointer write, no memory access, and `busy_o` stays low.
- R11: After reset, `busy_o`, `tail_o`, `sp_we_o`, `mem_we_o` and `mem_re_o` are low and no frame is open.
- R12: A memory store and a memory load are never requested in the same cycle. A cycle that stores to memory writes neither register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_i | input | 1 | Handler entry strobe from the interrupt controller |
| fp_en_i | input | 1 | Floating point enabled, sampled with `entry_i` |
| exit_i | input | 1 | Handler return strobe |
| pend_i | input | 1 | Another interrupt pending, sampled with `exit_i` |
| fp_use_i | input | 1 | First floating-point instruction in the handler |
| sp_i | input | AW | Current stack pointer |
| sp_we_o | output | 1 | Stack pointer write enable |
| sp_wdata_o | output | AW | New stack pointer value |
| rf_addr_o | output | 5 | Integer register index for read or write |
| rf_rdata_i | input | XLEN | Integer register read data (same cycle) |
| rf_we_o | output | 1 | Integer register write enable |
| rf_wdata_o | output | XLEN | Integer register write data |
| fpr_addr_o | output | 5 | Floating-point register index for read or write |
| fpr_rdata_i | input | XLEN | Floating-point register read data (same cycle) |
| fpr_we_o | output | 1 | Floating-point register write enable |
| fpr_wdata_o | output | XLEN | Floating-point register write data |
| mem_we_o | output | 1 | Memory word store request |
| mem_re_o | output | 1 | Memory word load request |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | XLEN | Store data |
| mem_rdata_i | input | XLEN | Load data (same cycle) |
| busy_o | output | 1 | Stacking or unstacking in progress; stalls the core |
| tail_o | output | 1 | One-cycle pulse: hand over to the next handler with the frame kept |

## Verification
The properties assume that the controller raises its strobes only while `busy_o` is low, that `entry_i` and `exit_i` are never raised together, and that register and memory reads answer within the same cycle. The properties also assume that exit strobes pair up with entries in last-in-first-out order. The stimulus keeps within these limits. Every strobe lasts one cycle and is driven at the falling edge, and the next one is not issued until `busy_o` has been seen low. The register-file and memory models answer combinationally from the addresses presented. The deliberately ignored cases (an exit with no frame open, a fifth entry, and unreserved or repeated floating-point use) are still only issued while the engine is idle.

// File: rtl/ictx_pkg.sv
package ictx_pkg;

  localparam int unsigned INT_SLOTS = 16;
  localparam int unsigned FP_SLOTS  = 20;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PUSH  = 3'd1,
    ST_FSAVE = 3'd2,
    ST_FLOAD = 3'd3,
    ST_ILOAD = 3'd4
  } ictx_state_e;

  // Caller-saved integer register for frame slot k:
  // x1, x5..x7, x10..x17, x28..x31
  function automatic logic [4:0] int_slot_reg(input logic [4:0] k);
    if (k == 5'd0)       return 5'd1;
    else if (k < 5'd4)   return k + 5'd4;
    else if (k < 5'd12)  return k + 5'd6;
    else                 return k + 5'd16;
  endfunction

  // Caller-saved floating-point register for lazy slot j:
  // f0..f7, f10..f17, f28..f31
  function automatic logic [4:0] fp_slot_reg(input logic [4:0] j);
    if (j < 5'd8)        return j;
    else if (j < 5'd16)  return j + 5'd2;
    else                 return j + 5'd12;
  endfunction

endpackage

// File: rtl/ictx_seq.sv
module ictx_seq
  import ictx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_push_i,
  input  logic        go_fsave_i,
  input  logic        go_pop_i,
  input  logic        pop_fp_i,
  output ictx_state_e state_o,
  output logic [4:0]  idx_o,
  output logic        last_o
);

  localparam logic [4:0] INT_LAST = 5'(INT_SLOTS - 1);
  localparam logic [4:0] FP_LAST  = 5'(FP_SLOTS - 1);

  ictx_state_e state_q;
  logic [4:0]  idx_q;
  logic        int_phase, fp_phase;

  assign int_phase = (state_q == ST_PUSH)  || (state_q == ST_ILOAD);
  assign fp_phase  = (state_q == ST_FSAVE) || (state_q == ST_FLOAD);
  assign last_o    = (int_phase && idx_q == INT_LAST) || (fp_phase && idx_q == FP_LAST);
  assign state_o   = state_q;
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (go_push_i)       state_q <= ST_PUSH;
          else if (go_pop_i)   state_q <= pop_fp_i ? ST_FLOAD : ST_ILOAD;
          else if (go_fsave_i) state_q <= ST_FSAVE;
        end
        ST_FLOAD: begin
          if (last_o) begin
            state_q <= ST_ILOAD;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 5'd1;
          end
        end
        ST_PUSH, ST_FSAVE, ST_ILOAD: begin
          if (last_o) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 5'd1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          idx_q   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ictx_frames.sv
module ictx_frames #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NEST = 4,
  localparam int unsigned LW  = $clog2(NEST + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_base_i,
  input  logic          push_fpres_i,
  input  logic          pop_i,
  input  logic          mark_i,
  output logic [LW-1:0] depth_o,
  output logic [AW-1:0] top_base_o,
  output logic          top_fpres_o,
  output logic          top_fpsv_o
);

  logic [LW-1:0] depth_q;
  logic [AW-1:0] base_q [NEST];
  logic [NEST-1:0] fpres_q, fpsv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 depth_q <= '0;
    else if (push_i && !pop_i)   depth_q <= depth_q + LW'(1);
    else if (pop_i && !push_i)   depth_q <= depth_q - LW'(1);
  end

  for (genvar g = 0; g < NEST; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        fpres_q[g] <= 1'b0;
        fpsv_q[g]  <= 1'b0;
      end else if (push_i && depth_q == LW'(g)) begin
        base_q[g]  <= push_base_i;
        fpres_q[g] <= push_fpres_i;
        fpsv_q[g]  <= 1'b0;
      end else if (mark_i && depth_q == LW'(g + 1)) begin
        fpsv_q[g]  <= 1'b1;
      end
    end
  end

  always_comb begin
    top_base_o  = '0;
    top_fpres_o = 1'b0;
    top_fpsv_o  = 1'b0;
    for (int g = 0; g < NEST; g++) begin
      if (depth_q == LW'(g + 1)) begin
        top_base_o  = base_q[g];
        top_fpres_o = fpres_q[g];
        top_fpsv_o  = fpsv_q[g];
      end
    end
  end

  assign depth_o = depth_q;

endmodule

// File: rtl/ictx_stacker.sv
module ictx_stacker
  import ictx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 32,
  parameter int unsigned NEST = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            entry_i,
  input  logic            fp_en_i,
  input  logic            exit_i,
  input  logic            pend_i,
  input  logic            fp_use_i,
  input  logic [AW-1:0]   sp_i,
  output logic            sp_we_o,
  output logic [AW-1:0]   sp_wdata_o,
  output logic [4:0]      rf_addr_o,
  input  logic [XLEN-1:0] rf_rdata_i,
  output logic            rf_we_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic [4:0]      fpr_addr_o,
  input  logic [XLEN-1:0] fpr_rdata_i,
  output logic            fpr_we_o,
  output logic [XLEN-1:0] fpr_wdata_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            busy_o,
  output logic            tail_o
);

  localparam int unsigned WB = XLEN / 8;
  localparam int unsigned LW = $clog2(NEST + 1);

  // Frame size in bytes for a given floating-point reservation
  function automatic logic [AW-1:0] frame_bytes(input logic fpres);
    return AW'((fpres ? (INT_SLOTS + FP_SLOTS) : INT_SLOTS) * WB);
  endfunction

  // Slot 0 sits at the highest word of a region of 'words' words
  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] base,
                                              input int unsigned words,
                                              input logic [4:0] slot);
    return base + AW'((words - 1 - int'(slot)) * WB);
  endfunction

  ictx_state_e   state;
  logic [4:0]    idx;
  logic          last;
  logic [LW-1:0] depth;
  logic [AW-1:0] top_base;
  logic          top_fpres, top_fpsv;

  // Named internal events
  logic idle, frame_open, room;
  logic take_entry, take_exit, take_chain, take_fsave;
  logic unstack_done, fsave_done;
  logic int_phase, fp_phase;
  logic [AW-1:0] entry_base, int_addr, fp_addr;

  assign idle       = (state == ST_IDLE);
  assign frame_open = (depth != '0);
  assign room       = (depth < LW'(NEST));

  assign take_entry = idle && entry_i && room;
  assign take_exit  = idle && !entry_i && exit_i && frame_open && !pend_i;
  assign take_chain = idle && !entry_i && exit_i && frame_open && pend_i;
  assign take_fsave = idle && !entry_i && !exit_i && fp_use_i && frame_open
                      && top_fpres && !top_fpsv;

  assign unstack_done = (state == ST_ILOAD) && last;
  assign fsave_done   = (state == ST_FSAVE) && last;
  assign int_phase    = (state == ST_PUSH)  || (state == ST_ILOAD);
  assign fp_phase     = (state == ST_FSAVE) || (state == ST_FLOAD);

  assign entry_base = sp_i - frame_bytes(fp_en_i);
  assign int_addr   = slot_addr(top_base,
                                top_fpres ? (INT_SLOTS + FP_SLOTS) : INT_SLOTS, idx);
  assign fp_addr    = slot_addr(top_base, FP_SLOTS, idx);

  ictx_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_push_i  (take_entry),
    .go_fsave_i (take_fsave),
    .go_pop_i   (take_exit),
    .pop_fp_i   (top_fpsv),
    .state_o    (state),
    .idx_o      (idx),
    .last_o     (last)
  );

  ictx_frames #(.AW(AW), .NEST(NEST)) u_frames (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (take_entry),
    .push_base_i  (entry_base),
    .push_fpres_i (fp_en_i),
    .pop_i        (unstack_done),
    .mark_i       (fsave_done),
    .depth_o      (depth),
    .top_base_o   (top_base),
    .top_fpres_o  (top_fpres),
    .top_fpsv_o   (top_fpsv)
  );

  assign sp_we_o    = take_entry || unstack_done;
  assign sp_wdata_o = take_entry ? entry_base : (top_base + frame_bytes(top_fpres));

  assign mem_we_o    = (state == ST_PUSH) || (state == ST_FSAVE);
  assign mem_re_o    = (state == ST_FLOAD) || (state == ST_ILOAD);
  assign mem_addr_o  = int_phase ? int_addr : (fp_phase ? fp_addr : '0);
  assign mem_wdata_o = (state == ST_PUSH)  ? rf_rdata_i :
                       (state == ST_FSAVE) ? fpr_rdata_i : '0;

  assign rf_addr_o   = int_phase ? int_slot_reg(idx) : 5'd0;
  assign rf_we_o     = (state == ST_ILOAD);
  assign rf_wdata_o  = rf_we_o ? mem_rdata_i : '0;
  assign fpr_addr_o  = fp_phase ? fp_slot_reg(idx) : 5'd0;
  assign fpr_we_o    = (state == ST_FLOAD);
  assign fpr_wdata_o = fpr_we_o ? mem_rdata_i : '0;

  assign busy_o = !idle;
  assign tail_o = take_chain;

endmodule

// File: rtl/ictx_chk.sv
module ictx_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned XLEN = 32,
  parameter int unsigned LW   = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          entry_i,
  input logic          exit_i,
  input logic          pend_i,
  input logic          fp_use_i,
  input logic          sp_we_o,
  input logic          busy_o,
  input logic          tail_o,
  input logic          mem_we_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rf_we_o,
  input logic          fpr_we_o,
  input logic          take_entry,
  input logic [LW-1:0] depth,
  input logic          top_fpres
);

  localparam logic [AW-1:0] WBY = AW'(XLEN / 8);

  // R12
  excl_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R12
  store_no_rf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!rf_we_o && !fpr_we_o));

  // R2
  store_descend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) - WBY));

  // R1
  entry_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_entry |=> busy_o);

  // R6
  unstack_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sp_we_o) |=> !busy_o);

  // R8
  chain_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && pend_i && !entry_i && !busy_o && depth != '0) |-> tail_o);

  // R8
  chain_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_o |=> (!busy_o && !mem_we_o && !mem_re_o));

  // R10
  empty_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && !entry_i && !busy_o && depth == '0) |=> !busy_o);

  // R5
  unreserved_fp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_use_i && !entry_i && !exit_i && !busy_o && !top_fpres) |=> !busy_o);

endmodule

bind ictx_stacker ictx_chk #(
  .AW   (AW),
  .XLEN (XLEN),
  .LW   ($clog2(NEST + 1))
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .entry_i    (entry_i),
  .exit_i     (exit_i),
  .pend_i     (pend_i),
  .fp_use_i   (fp_use_i),
  .sp_we_o    (sp_we_o),
  .busy_o     (busy_o),
  .tail_o     (tail_o),
  .mem_we_o   (mem_we_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .rf_we_o    (rf_we_o),
  .fpr_we_o   (fpr_we_o),
  .take_entry (take_entry),
  .depth      (depth),
  .top_fpres  (top_fpres)
);

// File: tb/ictx_stacker_tb_top.sv
module ictx_stacker_tb_top;

  localparam int XLEN = 32;
  localparam int AW   = 32;
  localparam int NEST = 4;
  localparam logic [31:0] SP0 = 32'h0000_0800;

  typedef struct {
    bit          st;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, entry_i, fp_en_i, exit_i, pend_i, fp_use_i, crpt;
  logic sp_we_o, rf_we_o, fpr_we_o, mem_we_o, mem_re_o, busy_o, tail_o;
  logic [31:0] sp_wdata_o, rf_wdata_o, fpr_wdata_o, mem_addr_o, mem_wdata_o;
  logic [31:0] rf_rdata_i, fpr_rdata_i, mem_rdata_i;
  logic [4:0]  rf_addr_o, fpr_addr_o;

  logic [31:0] int_rf [32];
  logic [31:0] fp_rf  [32];
  logic [31:0] mem    [1024];
  logic [31:0] sp;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  int IREG [16] = '{1, 5, 6, 7, 10, 11, 12, 13, 14, 15, 16, 17, 28, 29, 30, 31};
  int FREG [20] = '{0, 1, 2, 3, 4, 5, 6, 7, 10, 11, 12, 13, 14, 15, 16, 17, 28, 29, 30, 31};

  // Bench-side frame records
  int          blvl = 0;
  logic [31:0] bsp [NEST];
  bit          bfp [NEST];
  bit          bsv [NEST];
  logic [31:0] isnap [NEST][32];
  logic [31:0] fsnap [NEST][32];

  assign rf_rdata_i  = int_rf[rf_addr_o];
  assign fpr_rdata_i = fp_rf[fpr_addr_o];
  assign mem_rdata_i = mem[mem_addr_o[11:2]];

  ictx_stacker #(.XLEN(XLEN), .AW(AW), .NEST(NEST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .entry_i(entry_i), .fp_en_i(fp_en_i), .exit_i(exit_i), .pend_i(pend_i),
    .fp_use_i(fp_use_i), .sp_i(sp), .sp_we_o(sp_we_o), .sp_wdata_o(sp_wdata_o),
    .rf_addr_o(rf_addr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o),
    .fpr_addr_o(fpr_addr_o), .fpr_rdata_i(fpr_rdata_i), .fpr_we_o(fpr_we_o),
    .fpr_wdata_o(fpr_wdata_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .tail_o(tail_o)
  );

  // Core-side models: register files, memory, stack pointer
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) begin
        int_rf[i] <= 32'h1000_0000 + i;
        fp_rf[i]  <= 32'h2000_0000 + i;
      end
      sp <= SP0;
    end else begin
      if (crpt) begin
        for (int i = 0; i < 32; i++) begin
          int_rf[i] <= int_rf[i] ^ 32'h5A5A_0F0F ^ i;
          fp_rf[i]  <= fp_rf[i] ^ 32'hA5A5_F0F0 ^ (i << 8);
        end
      end
      if (sp_we_o)  sp <= sp_wdata_o;
      if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
      if (rf_we_o)  int_rf[rf_addr_o] <= rf_wdata_o;
      if (fpr_we_o) fp_rf[fpr_addr_o] <= fpr_wdata_o;
    end
  end

  task automatic chk_eq(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every memory access must match the next expected item
  always begin
    @(negedge clk);
    #8;
    if (rst_n && (mem_we_o || mem_re_o)) begin
      chk_eq("R12", "store and load together", 32'(mem_we_o && mem_re_o), 32'd0);
      if (q.size() == 0) begin
        chk_eq("R3", "unexpected memory access at", mem_addr_o, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk_eq(e.tag, "access kind", 32'(mem_we_o), 32'(e.st));
        chk_eq(e.tag, "access address", mem_addr_o, e.addr);
        if (e.st) chk_eq(e.tag, "store data", mem_wdata_o, e.data);
      end
    end
  end

  // Shared driver: one-cycle strobe, sample the strobe cycle, count busy cycles
  task automatic pulse(input bit e, input bit x, input bit p, input bit f, input bit u,
                       output bit spwe, output logic [31:0] spw, output bit tl,
                       output int nb);
    @(negedge clk);
    entry_i = e; exit_i = x; pend_i = p; fp_en_i = f; fp_use_i = u;
    #8;
    spwe = sp_we_o; spw = sp_wdata_o; tl = tail_o;
    @(negedge clk);
    entry_i = 0; exit_i = 0; pend_i = 0; fp_en_i = 0; fp_use_i = 0;
    #8;
    nb = 0;
    while (busy_o) begin
      nb++;
      @(negedge clk);
      #8;
    end
  endtask

  task automatic corrupt();
    @(negedge clk); crpt = 1;
    @(negedge clk); crpt = 0;
  endtask

  task automatic enter(input bit fp);
    bit spwe, tl; logic [31:0] spw; int nb; logic [31:0] old;
    bit room;
    room = (blvl < NEST);
    old = sp;
    if (room)
      for (int k = 0; k < 16; k++)
        q.push_back('{1'b1, old - 32'(4 * (k + 1)), int_rf[IREG[k]], "R2"});
    pulse(1, 0, 0, fp, 0, spwe, spw, tl, nb);
    if (room) begin
      chk_eq("R1", "entry sp write", 32'(spwe), 32'd1);
      chk_eq("R1", "entry sp value", spw, old - (fp ? 32'd144 : 32'd64));
      chk_eq("R1", "push busy cycles", 32'(nb), 32'd16);
      chk_eq(fp ? "R3" : "R2", "pending stores left", 32'(q.size()), 32'd0);
      bsp[blvl] = old; bfp[blvl] = fp; bsv[blvl] = 0;
      isnap[blvl] = int_rf;
      blvl++;
    end else begin
      chk_eq("R10", "full-depth sp write", 32'(spwe), 32'd0);
      chk_eq("R10", "full-depth busy", 32'(nb), 32'd0);
      chk_eq("R10", "full-depth sp", sp, old);
    end
  endtask

  task automatic fpuse(input string tag);
    bit spwe, tl; logic [31:0] spw; int nb; bit lazy;
    lazy = (blvl > 0) && bfp[blvl-1] && !bsv[blvl-1];
    if (lazy) begin
      for (int j = 0; j < 20; j++)
        q.push_back('{1'b1, bsp[blvl-1] - 32'(4 * (17 + j)), fp_rf[FREG[j]], "R4"});
      fsnap[blvl-1] = fp_rf;
    end
    pulse(0, 0, 0, 0, 1, spwe, spw, tl, nb);
    chk_eq(tag, "fp save busy cycles", 32'(nb), lazy ? 32'd20 : 32'd0);
    chk_eq(tag, "fp save sp write", 32'(spwe), 32'd0);
    chk_eq(tag, "fp stores left", 32'(q.size()), 32'd0);
    if (lazy) bsv[blvl-1] = 1;
  endtask

  task automatic leave(input bit pend);
    bit spwe, tl; logic [31:0] spw; int nb; int i; logic [31:0] old; logic [31:0] fpb [32];
    old = sp;
    if (blvl == 0) begin
      pulse(0, 1, pend, 0, 0, spwe, spw, tl, nb);
      chk_eq("R10", "empty exit sp write", 32'(spwe), 32'd0);
      chk_eq("R10", "empty exit busy", 32'(nb), 32'd0);
      chk_eq("R10", "empty exit sp", sp, old);
      return;
    end
    if (pend) begin
      pulse(0, 1, 1, 0, 0, spwe, spw, tl, nb);
      chk_eq("R8", "chain pulse", 32'(tl), 32'd1);
      chk_eq("R8", "chain sp write", 32'(spwe), 32'd0);
      chk_eq("R8", "chain busy", 32'(nb), 32'd0);
      chk_eq("R8", "chain sp kept", sp, old);
      return;
    end
    i = blvl - 1;
    fpb = fp_rf;
    if (bsv[i])
      for (int j = 0; j < 20; j++)
        q.push_back('{1'b0, bsp[i] - 32'(4 * (17 + j)), 32'd0, "R6"});
    for (int k = 0; k < 16; k++)
      q.push_back('{1'b0, bsp[i] - 32'(4 * (k + 1)), 32'd0, bfp[i] ? "R7" : "R6"});
    pulse(0, 1, 0, 0, 0, spwe, spw, tl, nb);
    chk_eq("R6", "unstack busy cycles", 32'(nb), bsv[i] ? 32'd36 : 32'd16);
    chk_eq(bfp[i] ? "R7" : "R6", "sp restored", sp, bsp[i]);
    chk_eq("R6", "loads left", 32'(q.size()), 32'd0);
    for (int k = 0; k < 16; k++)
      chk_eq("R6", $sformatf("x%0d restored", IREG[k]), int_rf[IREG[k]], isnap[i][IREG[k]]);
    for (int j = 0; j < 20; j++) begin
      if (bsv[i]) chk_eq("R6", $sformatf("f%0d restored", FREG[j]), fp_rf[FREG[j]], fsnap[i][FREG[j]]);
      else        chk_eq("R7", $sformatf("f%0d untouched", FREG[j]), fp_rf[FREG[j]], fpb[FREG[j]]);
    end
    blvl--;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; entry_i = 0; exit_i = 0; pend_i = 0; fp_en_i = 0; fp_use_i = 0; crpt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #8;
    // R11 reset state
    chk_eq("R11", "busy after reset", 32'(busy_o), 32'd0);
    chk_eq("R11", "tail after reset", 32'(tail_o), 32'd0);
    chk_eq("R11", "sp write after reset", 32'(sp_we_o), 32'd0);
    chk_eq("R11", "mem access after reset", 32'(mem_we_o || mem_re_o), 32'd0);

    // R1 R2 R6: plain frame
    enter(0); corrupt(); leave(0);
    // R3 R7: reserved FP space never filled
    enter(1); corrupt(); leave(0);
    // R4 R6: lazy save then full restore; second use ignored
    enter(1); fpuse("R4"); fpuse("R4"); corrupt(); leave(0);
    // R8: tail chain keeps the frame; R5: no reservation in frame
    enter(0); corrupt(); leave(1); fpuse("R5"); corrupt(); leave(0);
    // R5 and R10 with no frame open
    fpuse("R5"); leave(0);
    // R9: nested frames unwind in reverse order
    enter(0); corrupt(); enter(1); fpuse("R4"); corrupt(); leave(0); corrupt(); leave(0);
    // R10: entry at full depth is ignored
    for (int n = 0; n < NEST; n++) begin enter(n[0]); corrupt(); end
    enter(1);
    for (int n = 0; n < NEST; n++) leave(0);
    chk_eq("R9", "sp after full unwind", sp, SP0);
    repeat (4) @(negedge clk);
    chk_eq("R3", "unmatched expected items", 32'(q.size()), 32'd0);
    finish_run();
  end

endmodule